// File: doc/BRIEF.md
# System Control Register Unit

This unit sits next to a small CPU core and holds the control registers that the core uses for timer interrupts and for interrupt masking and reporting. These registers are separate from the general register file. The core moves data into them through a write port and reads them back through a read port. Both ports select a register by a 5-bit register number. There are four registers: a free-running counter, a compare value, a status word and a cause word.

The counter advances once every `CNT_DIV` clocks. When it equals the compare value, a sticky timer-pending flag is set. Only a new write to the compare register clears this flag. The cause word shows the timer flag and seven external interrupt lines, whatever their masks are. It also holds the exception code that the core reports. The status word holds a global enable and one mask bit per line. The unit drives a single interrupt request to the core.

Register numbers: counter 9, compare 11, status 12, cause 13.

Top module: `sys_ctrl_unit`

## Requirements
- R1: While rst_ni is low, the registers read as follows: counter 0, compare all ones, status 0, cause 0. irq_o is 0.
- R2: A write to register 9 loads the counter and restarts the clock divider. After that, the counter grows by 1 every CNT_DIV clocks (first increment CNT_DIV edges after the loading edge) and wraps from all ones to 0.
- R3: Register 11 reads back the last value written. While the counter equals the compare value, the next edge sets the timer-pending flag in cause bit 15. The flag stays set while compare is not written.
- R4: A write to register 11 clears the timer-pending flag. If the counter equals the old compare value in the same cycle as the write, the write wins and the flag stays 0.
- R5: Status (register 12) keeps bit 0 (global enable) and bits 15:8 (line masks, bit 15 for the timer, bit 8+k for external line k). All other bits read 0.
- R6: Cause bits 14:8 show ext_irq_i[6:0] as sampled at the previous edge. Cause bit 15 shows the timer flag. Both bits show whatever the masks are.
- R7: When exc_valid_i is high at an edge, exc_code_i is loaded into cause bits 6:2 (code 0 means interrupt). Otherwise the field holds its value.
- R8: irq_o is 1 only when status bit 0 is 1 and some cause bit in 15:8 has its matching status mask bit set.
- R9: Reading any register number other than 9, 11, 12 or 13 returns 0. Writes to those numbers, and writes to cause (13), change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Move-to write strobe |
| wr_sel_i | input | 5 | Register number for the write |
| wr_data_i | input | DATA_W | Write data |
| rd_sel_i | input | 5 | Register number for the read |
| rd_data_o | output | DATA_W | Read data (combinational) |
| ext_irq_i | input | 7 | External interrupt lines |
| exc_valid_i | input | 1 | Exception report strobe |
| exc_code_i | input | 5 | Exception code to record |
| irq_o | output | 1 | Interrupt request to the core |

## Verification
The timer match and a compare write can land in the same cycle. The write must win and the flag must stay clear. The bench loads the counter with a known value and sets compare a few counts ahead. It then counts edges so that the next compare write is sampled on exactly the edge where the counter equals the old compare. Cause bit 15 and irq_o are then read for several cycles and must stay 0. A plain match without a write, run earlier, shows that the flag does rise when nothing interferes.

// File: rtl/sys_ctrl_pkg.sv
package sys_ctrl_pkg;
  localparam int unsigned SEL_W   = 5;
  localparam int unsigned IP_W    = 8;
  localparam int unsigned EXT_W   = IP_W - 1;
  localparam int unsigned EXC_W   = 5;
  localparam int unsigned IP_LSB  = 8;
  localparam int unsigned EXC_LSB = 2;
  localparam int unsigned IE_BIT  = 0;

  localparam logic [SEL_W-1:0] SEL_COUNT   = 5'd9;
  localparam logic [SEL_W-1:0] SEL_COMPARE = 5'd11;
  localparam logic [SEL_W-1:0] SEL_STATUS  = 5'd12;
  localparam logic [SEL_W-1:0] SEL_CAUSE   = 5'd13;

  typedef struct packed {
    logic            ie;
    logic [IP_W-1:0] mask;
  } status_t;
endpackage

// File: rtl/sc_timer.sv
module sc_timer #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DIV    = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnt_we_i,
  input  logic              cmp_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] count_o,
  output logic [DATA_W-1:0] compare_o,
  output logic              pend_o
);
  logic              tick;
  logic [DATA_W-1:0] count_q, compare_q;
  logic              pend_q;

  generate
    if (DIV <= 1) begin : g_nodiv
      assign tick = 1'b1;
    end else begin : g_div
      localparam int unsigned DW = $clog2(DIV);
      localparam logic [DW-1:0] LAST = DW'(DIV - 1);
      logic [DW-1:0] div_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)           div_q <= '0;
        else if (cnt_we_i)     div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                   div_q <= div_q + 1'b1;
      end
      assign tick = (div_q == LAST);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       count_q <= '0;
    else if (cnt_we_i) count_q <= wdata_i;
    else if (tick)     count_q <= count_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       compare_q <= '1;
    else if (cmp_we_i) compare_q <= wdata_i;
  end

  // compare write outranks a match in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     pend_q <= 1'b0;
    else if (cmp_we_i)               pend_q <= 1'b0;
    else if (count_q == compare_q)   pend_q <= 1'b1;
  end

  assign count_o   = count_q;
  assign compare_o = compare_q;
  assign pend_o    = pend_q;
endmodule

// File: rtl/sc_status.sv
module sc_status
  import sys_ctrl_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  status_t           wdata_i,
  output status_t           status_o,
  output logic [DATA_W-1:0] value_o
);
  status_t st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   st_q <= '0;
    else if (we_i) st_q <= wdata_i;
  end

  always_comb begin
    value_o                  = '0;
    value_o[IE_BIT]          = st_q.ie;
    value_o[IP_LSB +: IP_W]  = st_q.mask;
  end

  assign status_o = st_q;
endmodule

// File: rtl/sc_cause.sv
module sc_cause
  import sys_ctrl_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [EXT_W-1:0]  ext_irq_i,
  input  logic              tmr_pend_i,
  input  logic              exc_valid_i,
  input  logic [EXC_W-1:0]  exc_code_i,
  output logic [IP_W-1:0]   ip_o,
  output logic [EXC_W-1:0]  code_o,
  output logic [DATA_W-1:0] value_o
);
  logic [EXT_W-1:0] ext_q;
  logic [EXC_W-1:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_q <= '0;
    else         ext_q <= ext_irq_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          code_q <= '0;
    else if (exc_valid_i) code_q <= exc_code_i;
  end

  assign ip_o   = {tmr_pend_i, ext_q};
  assign code_o = code_q;

  always_comb begin
    value_o                   = '0;
    value_o[IP_LSB +: IP_W]   = ip_o;
    value_o[EXC_LSB +: EXC_W] = code_q;
  end
endmodule

// File: rtl/sys_ctrl_unit.sv
module sys_ctrl_unit
  import sys_ctrl_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned CNT_DIV = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [4:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [4:0]        rd_sel_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [6:0]        ext_irq_i,
  input  logic              exc_valid_i,
  input  logic [4:0]        exc_code_i,
  output logic              irq_o
);
  logic              cnt_we, cmp_we, st_we;
  logic [DATA_W-1:0] count_q, compare_q, status_val, cause_val;
  logic              tmr_pend;
  status_t           st, st_d;
  logic [IP_W-1:0]   ip;
  logic [EXC_W-1:0]  exc_code_q;

  assign cnt_we = wr_en_i && (wr_sel_i == SEL_COUNT);
  assign cmp_we = wr_en_i && (wr_sel_i == SEL_COMPARE);
  assign st_we  = wr_en_i && (wr_sel_i == SEL_STATUS);

  assign st_d.ie   = wr_data_i[IE_BIT];
  assign st_d.mask = wr_data_i[IP_LSB +: IP_W];

  sc_timer #(.DATA_W(DATA_W), .DIV(CNT_DIV)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cnt_we_i  (cnt_we),
    .cmp_we_i  (cmp_we),
    .wdata_i   (wr_data_i),
    .count_o   (count_q),
    .compare_o (compare_q),
    .pend_o    (tmr_pend)
  );

  sc_status #(.DATA_W(DATA_W)) u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (st_we),
    .wdata_i  (st_d),
    .status_o (st),
    .value_o  (status_val)
  );

  sc_cause #(.DATA_W(DATA_W)) u_cause (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ext_irq_i   (ext_irq_i),
    .tmr_pend_i  (tmr_pend),
    .exc_valid_i (exc_valid_i),
    .exc_code_i  (exc_code_i),
    .ip_o        (ip),
    .code_o      (exc_code_q),
    .value_o     (cause_val)
  );

  always_comb begin
    case (rd_sel_i)
      SEL_COUNT:   rd_data_o = count_q;
      SEL_COMPARE: rd_data_o = compare_q;
      SEL_STATUS:  rd_data_o = status_val;
      SEL_CAUSE:   rd_data_o = cause_val;
      default:     rd_data_o = '0;
    endcase
  end

  assign irq_o = st.ie && |(ip & st.mask);
endmodule

// File: rtl/sys_ctrl_unit_chk.sv
module sys_ctrl_unit_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [4:0]        wr_sel_i,
  input logic [4:0]        rd_sel_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              exc_valid_i,
  input logic              irq_o,
  input logic [DATA_W-1:0] count_q,
  input logic              tmr_pend,
  input logic              st_ie,
  input logic [7:0]        ip,
  input logic [7:0]        st_mask,
  input logic [4:0]        exc_code_q
);
  logic cnt_wr, cmp_wr;
  assign cnt_wr = wr_en_i && (wr_sel_i == 5'd9);
  assign cmp_wr = wr_en_i && (wr_sel_i == 5'd11);

  // R2
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cnt_wr) |-> (count_q == $past(count_q)) || (count_q == $past(count_q) + 1'b1));

  // R3
  pend_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(tmr_pend) && !$past(cmp_wr)) |-> tmr_pend);

  // R4
  pend_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cmp_wr) |-> !tmr_pend);

  // R5
  status_rsvd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_sel_i == 5'd12) |-> (rd_data_o[7:1] == '0) && (rd_data_o[DATA_W-1:16] == '0));

  // R7
  exc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(exc_valid_i) |-> $stable(exc_code_q));

  // R8
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> st_ie && ((ip & st_mask) != '0));

  // R9
  unimpl_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_sel_i inside {5'd9, 5'd11, 5'd12, 5'd13}) |-> (rd_data_o == '0));
endmodule

bind sys_ctrl_unit sys_ctrl_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_sel_i    (wr_sel_i),
  .rd_sel_i    (rd_sel_i),
  .rd_data_o   (rd_data_o),
  .exc_valid_i (exc_valid_i),
  .irq_o       (irq_o),
  .count_q     (count_q),
  .tmr_pend    (tmr_pend),
  .st_ie       (st.ie),
  .ip          (ip),
  .st_mask     (st.mask),
  .exc_code_q  (exc_code_q)
);

// File: tb/sim_sys_ctrl_unit.sv
module sim_sys_ctrl_unit;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [4:0] R_CNT = 5'd9, R_CMP = 5'd11, R_ST = 5'd12, R_CA = 5'd13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_sel = '0;
  logic [31:0] rd0, rd1;
  logic [6:0]  ext = '0;
  logic        exc_v = 1'b0;
  logic [4:0]  exc_c = '0;
  logic        irq0, irq1;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sys_ctrl_unit #(.DATA_W(32), .CNT_DIV(1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .rd_sel_i(rd_sel), .rd_data_o(rd0), .ext_irq_i(ext), .exc_valid_i(exc_v),
    .exc_code_i(exc_c), .irq_o(irq0));

  sys_ctrl_unit #(.DATA_W(32), .CNT_DIV(3)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .rd_sel_i(rd_sel), .rd_data_o(rd1), .ext_irq_i(ext), .exc_valid_i(exc_v),
    .exc_code_i(exc_c), .irq_o(irq1));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [4:0] s, logic [31:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [4:0] s, output logic [31:0] v);
    rd_sel = s; #1; v = rd0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(R_CNT, v); chk("R1 count", v, 32'h0);
    rd(R_CMP, v); chk("R1 compare", v, 32'hFFFF_FFFF);
    rd(R_ST, v);  chk("R1 status", v, 32'h0);
    rd(R_CA, v);  chk("R1 cause", v, 32'h0);
    chk("R1 irq", {31'h0, irq0}, 32'h0);
  endtask

  task automatic t_count();
    logic [31:0] v;
    wr(R_CNT, 32'd100); rd(R_CNT, v); chk("R2 load", v, 32'd100);
    step(5); rd(R_CNT, v); chk("R2 increment", v, 32'd105);
    wr(R_CNT, 32'hFFFF_FFFE); step(1); rd(R_CNT, v); chk("R2 all ones", v, 32'hFFFF_FFFF);
    step(1); rd(R_CNT, v); chk("R2 wrap", v, 32'h0);
  endtask

  task automatic t_timer();
    logic [31:0] v;
    wr(R_ST, 32'h0000_8001);
    wr(R_CNT, 32'd0);
    wr(R_CMP, 32'd10);
    rd(R_CMP, v); chk("R3 compare readback", v, 32'd10);
    step(9); rd(R_CA, v); chk("R3 before match", {31'h0, v[15]}, 32'h0);
    step(1); rd(R_CA, v); chk("R3 after match", {31'h0, v[15]}, 32'h1);
    chk("R8 timer irq", {31'h0, irq0}, 32'h1);
    step(5); rd(R_CA, v); chk("R3 sticky", {31'h0, v[15]}, 32'h1);
    wr(R_ST, 32'h0000_0001); rd(R_CA, v);
    chk("R6 raw pending unmasked", {31'h0, v[15]}, 32'h1);
    chk("R8 masked off", {31'h0, irq0}, 32'h0);
    wr(R_ST, 32'h0000_8000); chk("R8 global off", {31'h0, irq0}, 32'h0);
    wr(R_ST, 32'h0000_8001); chk("R8 both on", {31'h0, irq0}, 32'h1);
    wr(R_ST, 32'hFFFF_FFFF); rd(R_ST, v); chk("R5 status bits", v, 32'h0000_FF01);
    wr(R_CMP, 32'h7FFF_FFFF); rd(R_CA, v);
    chk("R4 clear on write", {31'h0, v[15]}, 32'h0);
    chk("R4 irq dropped", {31'h0, irq0}, 32'h0);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    wr(R_CNT, 32'd200);
    wr(R_CMP, 32'd205);
    step(4); rd(R_CNT, v); chk("R4 count at match", v, 32'd205);
    wr(R_CMP, 32'h7000_0000); rd(R_CA, v);
    chk("R4 write wins over match", {31'h0, v[15]}, 32'h0);
    step(3); rd(R_CA, v); chk("R4 still clear", {31'h0, v[15]}, 32'h0);
    chk("R4 no irq", {31'h0, irq0}, 32'h0);
  endtask

  task automatic t_ext();
    logic [31:0] v;
    wr(R_ST, 32'h0000_0001);
    ext = 7'b000_0101; step(1); rd(R_CA, v);
    chk("R6 ext lines", v, 32'h0000_0500);
    chk("R8 ext masked", {31'h0, irq0}, 32'h0);
    wr(R_ST, 32'h0000_0401); chk("R8 ext line 2 enabled", {31'h0, irq0}, 32'h1);
    ext = '0; step(1); rd(R_CA, v);
    chk("R6 ext cleared", v, 32'h0);
    chk("R8 ext irq gone", {31'h0, irq0}, 32'h0);
  endtask

  task automatic t_exc();
    logic [31:0] v;
    exc_v = 1'b1; exc_c = 5'd12; step(1);
    exc_v = 1'b0; exc_c = 5'd5; rd(R_CA, v); chk("R7 code captured", v, 32'h30);
    step(2); rd(R_CA, v); chk("R7 code held", v, 32'h30);
    exc_v = 1'b1; exc_c = 5'd0; step(1); exc_v = 1'b0;
    rd(R_CA, v); chk("R7 interrupt code", v, 32'h0);
  endtask

  task automatic t_unimpl();
    logic [31:0] v;
    wr(5'd5, 32'h1234); rd(5'd5, v); chk("R9 read unimpl 5", v, 32'h0);
    rd(5'd0, v); chk("R9 read unimpl 0", v, 32'h0);
    rd(5'd31, v); chk("R9 read unimpl 31", v, 32'h0);
    wr(5'd10, 32'hABCD); rd(R_CMP, v); chk("R9 compare untouched", v, 32'h7000_0000);
    rd(R_ST, v); chk("R9 status untouched", v, 32'h0000_0401);
    wr(R_CA, 32'hFFFF_FFFF); rd(R_CA, v); chk("R9 cause read-only", v, 32'h0);
  endtask

  task automatic t_prescale();
    wr(R_CNT, 32'd0);
    rd_sel = R_CNT; #1; chk("R2 div3 load", rd1, 32'd0);
    step(2); #1; chk("R2 div3 hold", rd1, 32'd0);
    step(1); #1; chk("R2 div3 first tick", rd1, 32'd1);
    step(3); #1; chk("R2 div3 second tick", rd1, 32'd2);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    step(2);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    step(1);
    t_count();
    t_timer();
    t_collide();
    t_ext();
    t_exc();
    t_unimpl();
    t_prescale();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule